// File: doc/BRIEF.md
# Pipelined Late-Write Synchronous SRAM

This block is the synchronous control pipeline of a single-port SRAM whose data bus never needs an idle cycle between reads and writes. On each recognised rising clock edge it samples an address, three chip selects, a write strobe, per-lane write strobes and an advance/load control. The read data for a command sampled at one edge sits in a registered output stage until the next recognised edge. The write data for a command sampled at one edge is taken from the bus at the next recognised edge and committed to the array there. Both data phases therefore occupy the same cycle slot, so reads and writes can alternate on every cycle.

The data word is split into byte lanes. Each lane carries eight data bits and one parity bit, and each lane has its own write strobe. A two-bit burst counter lets a host issue one loaded address followed by advance cycles, in either linear or interleaved order. A global clock enable freezes the whole pipeline without deselecting it. An asynchronous output enable gates the bus drive. The drive is always off for write and deselect data phases.

Top module: `nbt_sram`

## Requirements
- R1: While `clk_en_n` is high at a rising edge, that edge is ignored: `bus_out`, the drive state, the burst counter and any pending write stay unchanged, and the device stays selected.
- R2: A load edge (`advance`=0, `clk_en_n`=0) selects the device only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. Any other combination is a deselect, and `bus_drive` is 0 in the data phase that follows.
- R3: A selected load edge with `wr_n`=1 reads the word at `addr`. That word is on `bus_out` from just after this edge until the next recognised edge, and it is driven when `drive_en_n` is 0.
- R4: Each recognised edge with `advance`=1 steps a 2-bit burst count n by one, wrapping after four. The accessed address keeps the upper bits of the loaded address. Its low two bits are (start + n) mod 4 when `order_sel`=0 (linear), and start XOR n when `order_sel`=1 (interleaved).
- R5: An advance edge that follows a deselect, or that follows reset, continues the deselect: no access is made and `bus_drive` stays 0.
- R6: An advance edge continues the previous read or write whatever `sel_a_n`, `sel_b`, `sel_c_n` and `wr_n` are. `lane_wr_n` is sampled again on each advance write edge.
- R7: Write data is sampled from `bus_in` at the recognised edge after the write command. Lane l is bits [9l+8:9l], with bit 9l+8 as that lane's parity bit. A lane is written only if `lane_wr_n[l]` was 0 at the command edge.
- R8: A read issued at the edge that commits a write to the same address returns the newly written lanes, merged with the old contents of the unwritten lanes.
- R9: `bus_drive` is 0 during the data phase of a write, whatever `drive_en_n` is.
- R10: `bus_drive` is 0 whenever `drive_en_n` is 1, without waiting for a clock edge.
- R11: A clock edge with `rst_n` low leaves the device deselected, with `bus_drive` 0 and no pending write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| clk_en_n | input | 1 | Clock enable, active low |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| advance | input | 1 | 1 = advance burst, 0 = load new address |
| wr_n | input | 1 | 0 = write command, 1 = read command |
| lane_wr_n | input | LANES | Per-lane write strobes, active low |
| order_sel | input | 1 | Burst order: 0 linear, 1 interleaved |
| drive_en_n | input | 1 | Asynchronous output enable, active low |
| addr | input | ADDR_W | Word address |
| bus_in | input | LANES*LANE_W | Data from the bus |
| bus_out | output | LANES*LANE_W | Read data towards the bus |
| bus_drive | output | 1 | Bus driver enable |

## Verification
The hardest situation to reach is a read that lands on the same edge as the commit of a partial write to the same word. Reaching it needs back-to-back write and read commands, a mask that leaves some lanes untouched, and write data placed on the bus one cycle after its own command. The bench drives strict write/read alternation with rotating lane masks, so a read always meets the commit of the write just before it. It also stretches a write data phase with clock-enable holds while junk is on the bus, to confirm that capture happens only at the next recognised edge.

// File: rtl/nbt_sram_pkg.sv
// Shared types and helpers for the late-write SRAM pipeline.
// Assumes a burst of four words addressed by the two low address bits.
package nbt_sram_pkg;

    localparam int BURST_W = 2;

    // Operation carried by the current data phase; also what an advance continues.
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    // Low address bits for burst step n from a start offset.
    function automatic logic [BURST_W-1:0] burst_ofs(
        input logic [BURST_W-1:0] start,
        input logic [BURST_W-1:0] step,
        input logic               interleave
    );
        return interleave ? (start ^ step) : (start + step);
    endfunction

endpackage

// File: rtl/nbt_sram_addr_seq.sv
// Address sequencer: holds the loaded base address and the burst count.
// Produces the address of the access made at the current edge.
// Assumes ADDR_W > BURST_W. It advances only on recognised edges (step_en).
module nbt_sram_addr_seq
    import nbt_sram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_en,
    input  logic              load_en,
    input  logic              adv_en,
    input  logic              interleave,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic [ADDR_W-1:0] acc_addr
);

    logic [ADDR_W-1:0]  base_q;
    logic [BURST_W-1:0] cnt_q;
    logic [BURST_W-1:0] cnt_nxt;

    // Next burst count and the address of this edge's access.
    always_comb begin
        cnt_nxt = cnt_q + BURST_W'(1);
        if (load_en) begin
            acc_addr = ext_addr;
        end else begin
            acc_addr = {base_q[ADDR_W-1:BURST_W],
                        burst_ofs(base_q[BURST_W-1:0], cnt_nxt, interleave)};
        end
    end

    // Capture the base on a load and step the count on an advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= '0;
        end else if (step_en) begin
            if (load_en) begin
                base_q <= ext_addr;
                cnt_q  <= '0;
            end else if (adv_en) begin
                cnt_q  <= cnt_nxt;
            end
        end
    end

endmodule

// File: rtl/nbt_sram_ctrl.sv
// Command decoder and pipeline state. It decides the operation for each
// recognised edge and keeps the pending write (address and lane mask) until
// its data arrives at the next recognised edge.
// Assumes step_en is the recognised-edge qualifier (clock enable active).
module nbt_sram_ctrl
    import nbt_sram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_en,
    input  logic              advance,
    input  logic              sel_a_n,
    input  logic              sel_b,
    input  logic              sel_c_n,
    input  logic              wr_n,
    input  logic [LANES-1:0]  lane_wr_n,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic              load_en,
    output logic              adv_en,
    output logic              rd_now,
    output logic              commit_en,
    output logic [ADDR_W-1:0] pend_addr,
    output logic [LANES-1:0]  pend_mask,
    output op_e               op_cur
);

    op_e  op_q;
    op_e  op_nxt;
    logic pend_v;
    logic selected;

    // Decode the command presented at this edge.
    always_comb begin
        selected = !sel_a_n && sel_b && !sel_c_n;
        load_en  = !advance;
        adv_en   = advance && (op_q != OP_IDLE);
        if (!advance) begin
            if (selected) op_nxt = wr_n ? OP_READ : OP_WRITE;
            else          op_nxt = OP_IDLE;
        end else begin
            op_nxt = op_q;
        end
    end

    // Strobes to the array for this edge.
    always_comb begin
        rd_now    = rst_n && step_en && (op_nxt == OP_READ);
        commit_en = rst_n && step_en && pend_v;
        op_cur    = op_q;
    end

    // Register the operation and the pending write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q      <= OP_IDLE;
            pend_v    <= 1'b0;
            pend_addr <= '0;
            pend_mask <= '0;
        end else if (step_en) begin
            op_q      <= op_nxt;
            pend_v    <= (op_nxt == OP_WRITE);
            pend_addr <= acc_addr;
            pend_mask <= ~lane_wr_n;
        end
    end

endmodule

// File: rtl/nbt_sram_lane.sv
// One byte lane (data plus parity) of the array with its output register.
// A read that meets a write to the same word at the same edge returns the
// write data. Assumes the caller gates both strobes with the clock enable.
module nbt_sram_lane #(
    parameter int ADDR_W = 6,
    parameter int LANE_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [LANE_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [LANE_W-1:0] q
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [LANE_W-1:0] mem [DEPTH];

    // Array write port.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    // Output register with forwarding from the write committed at this edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (rd_en) begin
            if (wr_en && (wr_addr == rd_addr)) q <= wr_data;
            else                               q <= mem[rd_addr];
        end
    end

endmodule

// File: rtl/nbt_sram.sv
// Pipelined late-write SRAM: address sequencer, command control and a
// generated set of byte lanes. Read data is registered at the command edge.
// Write data is taken at the next recognised edge. The bus drive is on only
// in a read data phase with the output enable low.
module nbt_sram
    import nbt_sram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 8,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clk_en_n,
    input  logic                    sel_a_n,
    input  logic                    sel_b,
    input  logic                    sel_c_n,
    input  logic                    advance,
    input  logic                    wr_n,
    input  logic [LANES-1:0]        lane_wr_n,
    input  logic                    order_sel,
    input  logic                    drive_en_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] bus_in,
    output logic [LANES*LANE_W-1:0] bus_out,
    output logic                    bus_drive
);

    logic              step_en;
    logic              load_en;
    logic              adv_en;
    logic              rd_now;
    logic              commit_en;
    logic [ADDR_W-1:0] acc_addr;
    logic [ADDR_W-1:0] pend_addr;
    logic [LANES-1:0]  pend_mask;
    op_e               op_cur;

    assign step_en = !clk_en_n;

    nbt_sram_addr_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_en    (step_en),
        .load_en    (load_en),
        .adv_en     (adv_en),
        .interleave (order_sel),
        .ext_addr   (addr),
        .acc_addr   (acc_addr)
    );

    nbt_sram_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_en   (step_en),
        .advance   (advance),
        .sel_a_n   (sel_a_n),
        .sel_b     (sel_b),
        .sel_c_n   (sel_c_n),
        .wr_n      (wr_n),
        .lane_wr_n (lane_wr_n),
        .acc_addr  (acc_addr),
        .load_en   (load_en),
        .adv_en    (adv_en),
        .rd_now    (rd_now),
        .commit_en (commit_en),
        .pend_addr (pend_addr),
        .pend_mask (pend_mask),
        .op_cur    (op_cur)
    );

    // One storage lane per byte strobe.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        nbt_sram_lane #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (commit_en && pend_mask[l]),
            .wr_addr (pend_addr),
            .wr_data (bus_in[l*LANE_W +: LANE_W]),
            .rd_en   (rd_now),
            .rd_addr (acc_addr),
            .q       (bus_out[l*LANE_W +: LANE_W])
        );
    end

    // Drive only in a read data phase; the output enable acts without a clock.
    always_comb begin
        bus_drive = (op_cur == OP_READ) && !drive_en_n;
    end

endmodule

// File: rtl/nbt_sram_chk.sv
// Protocol checker for nbt_sram, attached by bind. It observes the ports and
// the current data-phase operation.
module nbt_sram_chk
    import nbt_sram_pkg::*;
#(
    parameter int DATA_W = 72
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clk_en_n,
    input logic              sel_a_n,
    input logic              sel_b,
    input logic              sel_c_n,
    input logic              advance,
    input logic              wr_n,
    input logic              drive_en_n,
    input logic [DATA_W-1:0] bus_out,
    input logic              bus_drive,
    input op_e               op_cur
);

    logic picked;
    assign picked = !sel_a_n && sel_b && !sel_c_n;

    // R1: an ignored edge changes neither the output data nor the phase.
    p_hold_data_r1: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en_n |=> $stable(bus_out));
    p_hold_phase_r1: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en_n |=> (op_cur == $past(op_cur)));

    // R2: a load without full selection gives an undriven data phase.
    p_desel_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && !advance && !picked) |=> !bus_drive);

    // R5: advancing while deselected stays deselected.
    p_adv_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && advance && (op_cur == OP_IDLE)) |=> !bus_drive);

    // R9: a write data phase is never driven.
    p_wr_phase_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && !advance && picked && !wr_n) |=> !bus_drive);

    // R10: output enable high blocks the drive.
    p_oe_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
        drive_en_n |-> !bus_drive);

    // R11: reset leaves the bus undriven.
    p_reset_r11: assert property (@(posedge clk)
        !rst_n |=> !bus_drive);

endmodule

bind nbt_sram nbt_sram_chk #(.DATA_W(LANES*LANE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clk_en_n   (clk_en_n),
    .sel_a_n    (sel_a_n),
    .sel_b      (sel_b),
    .sel_c_n    (sel_c_n),
    .advance    (advance),
    .wr_n       (wr_n),
    .drive_en_n (drive_en_n),
    .bus_out    (bus_out),
    .bus_drive  (bus_drive),
    .op_cur     (op_cur)
);

// File: tb/sim_nbt_sram.sv
// Bench for nbt_sram: a behavioural reference model stepped at each edge and
// compared with the outputs at every falling edge.
module sim_nbt_sram;

    localparam int AW = 6;
    localparam int LN = 8;
    localparam int LW = 9;
    localparam int DW = LN * LW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clk_en_n = 1'b0;
    logic          sel_a_n = 1'b1;
    logic          sel_b = 1'b0;
    logic          sel_c_n = 1'b1;
    logic          advance = 1'b0;
    logic          wr_n = 1'b1;
    logic [LN-1:0] lane_wr_n = '1;
    logic          order_sel = 1'b0;
    logic          drive_en_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] bus_in = '0;
    logic [DW-1:0] bus_out;
    logic          bus_drive;

    always #4 clk = ~clk;

    nbt_sram #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) u0 (
        .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .sel_a_n(sel_a_n),
        .sel_b(sel_b), .sel_c_n(sel_c_n), .advance(advance), .wr_n(wr_n),
        .lane_wr_n(lane_wr_n), .order_sel(order_sel), .drive_en_n(drive_en_n),
        .addr(addr), .bus_in(bus_in), .bus_out(bus_out), .bus_drive(bus_drive)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // Reference model state.
    logic [DW-1:0] m_mem [1 << AW];
    int            m_op = 0;      // 0 idle, 1 read, 2 write
    logic [AW-1:0] m_base = '0;
    int            m_cnt = 0;
    bit            m_pv = 0;
    logic [AW-1:0] m_pa = '0;
    logic [LN-1:0] m_pm = '0;
    logic [DW-1:0] m_q = '0;
    logic [DW-1:0] nxt_d = '0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] pat(input int a, input int salt);
        logic [DW-1:0] v;
        for (int l = 0; l < LN; l++) v[l*LW +: LW] = LW'(a * 7 + l * 13 + salt * 29 + 1);
        return v;
    endfunction

    // Advance the model by one rising edge using the inputs held at that edge.
    task automatic model_edge();
        logic [AW-1:0] acc;
        logic [1:0]    c2;
        int            nop;
        acc = '0;
        if (!rst_n) begin
            m_op = 0; m_pv = 0; m_base = '0; m_cnt = 0; m_q = '0;
        end else if (!clk_en_n) begin
            if (m_pv)
                for (int l = 0; l < LN; l++)
                    if (m_pm[l]) m_mem[m_pa][l*LW +: LW] = bus_in[l*LW +: LW];
            if (!advance) begin
                if (!sel_a_n && sel_b && !sel_c_n) begin
                    nop = wr_n ? 1 : 2; m_base = addr; m_cnt = 0; acc = addr;
                end else nop = 0;
            end else begin
                nop = m_op;
                if (nop != 0) begin
                    m_cnt = (m_cnt + 1) % 4;
                    c2 = 2'(m_cnt);
                    acc = {m_base[AW-1:2], order_sel ? (m_base[1:0] ^ c2) : (m_base[1:0] + c2)};
                end
            end
            m_op = nop; m_pv = (nop == 2); m_pa = acc; m_pm = ~lane_wr_n;
            if (nop == 1) m_q = m_mem[acc];
        end
    endtask

    task automatic compare(input string tag);
        logic exp_drive;
        exp_drive = (m_op == 1) && !drive_en_n;
        chk(bus_drive == exp_drive, tag, "drive", DW'(bus_drive), DW'(exp_drive));
        if (m_op == 1) chk(bus_out == m_q, tag, "data", bus_out, m_q);
    endtask

    task automatic issue(input string tag);
        bus_in = nxt_d;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare(tag);
    endtask

    task automatic select(input bit on);
        sel_a_n = !on; sel_b = on; sel_c_n = !on;
    endtask

    task automatic wr(input int a, input logic [LN-1:0] strobe_n,
                      input logic [DW-1:0] d, input string tag);
        clk_en_n = 0; advance = 0; select(1); wr_n = 0; lane_wr_n = strobe_n; addr = AW'(a);
        issue(tag);
        nxt_d = d;
    endtask

    task automatic rd(input int a, input string tag);
        clk_en_n = 0; advance = 0; select(1); wr_n = 1; addr = AW'(a);
        issue(tag);
    endtask

    task automatic adv(input bit junk_sel, input bit junk_wr, input logic [LN-1:0] strobe_n,
                       input logic [DW-1:0] d, input string tag);
        clk_en_n = 0; advance = 1; select(!junk_sel); wr_n = junk_wr; lane_wr_n = strobe_n;
        addr = ~addr;
        issue(tag);
        nxt_d = d;
    endtask

    task automatic hold(input int n, input string tag);
        logic [DW-1:0] keep;
        keep = nxt_d;
        for (int i = 0; i < n; i++) begin
            clk_en_n = 1; advance = i[0]; select(i[0]); wr_n = !wr_n; addr = AW'(i * 5);
            nxt_d = ~keep;
            issue(tag);
        end
        nxt_d = keep;
        clk_en_n = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        for (int a = 0; a < (1 << AW); a++) m_mem[a] = '0;
        @(negedge clk);
        // R11: reset state.
        rst_n = 0;
        for (int i = 0; i < 3; i++) issue("R11");
        rst_n = 1;
        // R5/R11: advance straight after reset makes no access.
        clk_en_n = 0; advance = 1; select(1); wr_n = 1;
        issue("R5");
        // R7: fill every word with full-lane writes.
        for (int a = 0; a < (1 << AW); a++) wr(a, '0, pat(a, 0), "R7");
        rd(0, "R3");
        for (int a = 1; a < (1 << AW); a += 9) rd(a, "R3");
        // R8/R7/R9: strict write/read alternation with partial masks.
        for (int i = 0; i < 16; i++) begin
            wr((i * 3) % 64, LN'(8'hA5 ^ i), pat(i, 5), "R9");
            rd((i * 3) % 64, "R8");
            wr((i * 5 + 1) % 64, LN'(8'h3C + i), pat(i, 7), "R7");
            rd((i * 11 + 2) % 64, "R3");
        end
        // R4: linear burst from an unaligned start, including wrap.
        order_sel = 0;
        rd(6, "R4");
        for (int i = 0; i < 4; i++) adv(0, 1, '1, '0, "R4");
        // R4: interleaved burst.
        order_sel = 1;
        rd(13, "R4");
        for (int i = 0; i < 4; i++) adv(0, 1, '1, '0, "R4");
        // R6: write burst with junk selects and write strobe, then read it back.
        order_sel = 0;
        wr(20, '0, pat(20, 9), "R6");
        adv(1, 1, 8'h0F, pat(21, 9), "R6");
        adv(1, 1, 8'hF0, pat(22, 9), "R6");
        adv(1, 0, 8'h00, pat(23, 9), "R6");
        rd(20, "R6");
        for (int i = 0; i < 3; i++) adv(1, 0, '0, '0, "R6");
        // R1: freeze during a read data phase.
        rd(30, "R1");
        hold(3, "R1");
        adv(0, 1, '1, '0, "R1");
        // R1/R7: freeze a write data phase with junk on the bus.
        wr(40, 8'h55, pat(40, 3), "R1");
        hold(2, "R1");
        rd(40, "R7");
        // R2: deselect by each chip select in turn, then R5 advance.
        for (int k = 0; k < 3; k++) begin
            rd(k + 50, "R3");
            clk_en_n = 0; advance = 0; select(1); wr_n = 1;
            if (k == 0) sel_a_n = 1; else if (k == 1) sel_b = 0; else sel_c_n = 1;
            issue("R2");
            adv(0, 1, '1, '0, "R5");
        end
        // R10: output enable high blocks a read, and acts without a clock.
        drive_en_n = 1;
        rd(33, "R10");
        drive_en_n = 0;
        #1 chk(bus_drive == 1'b1, "R10", "drive after enable low", DW'(bus_drive), DW'(1));
        drive_en_n = 1;
        #1 chk(bus_drive == 1'b0, "R10", "drive after enable high", DW'(bus_drive), DW'(0));
        drive_en_n = 0;
        rd(33, "R3");
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule